// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block is the gatekeeper for writes to a 4096-byte serial EEPROM. The command decoder in front of it hands it one-cycle strobes: arm the write latch, disarm it, load the status register with a data byte, or write a memory byte at a 16-bit address. For each status or memory write, the block answers one clock later with a one-cycle accept or reject pulse. The memory sequencer acts only on the accept pulse.

The block holds a small amount of state: the write latch, a lock bit and a two-bit protection level. The lock bit and the protection level are loaded by status writes. It also samples an active-low write-protect pin through a synchronizer. When the lock bit is set and the synchronized pin is low, the block is hard-locked. In that state, status writes are refused, which freezes the protection level and therefore the protected address range. The hard lock can be reached in either order (lock bit first or pin first). It is left only by releasing the pin high. The current state reads back as a status byte.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset the status byte is 0x00 (lock bit clear, level 00, latch clear) and neither accept nor reject is asserted.
- R2: A write-disarm strobe clears the write latch and a write-arm strobe sets it; the result is visible in the status byte one cycle later.
- R3: A status write or memory write arriving while the write latch is clear is rejected, and a rejected request leaves latch, lock bit and level unchanged.
- R4: Every accepted status or memory write clears the write latch.
- R5: While the lock bit is 0, a status write with the latch set is accepted at either pin level; the byte loads the lock bit from data bit 7 and the level from data bits 3:2.
- R6: While the lock bit is 1 and the synchronized pin is high, a status write with the latch set is accepted.
- R7: While the lock bit is 1 and the synchronized pin is low, every status write is rejected, whether the pin went low before or after the lock bit was set; driving the pin high makes status writes acceptable again.
- R8: The write-protect pin passes through SYNC_STAGES (default 2) flip-flops before it has effect, so a status write evaluated within two clock edges of the pin falling still sees the pin high.
- R9: A memory write with the latch set is rejected when the array address lies in the protected range: level 00 none, 01 0xC00 to 0xFFF, 10 0x800 to 0xFFF, 11 the whole array; otherwise it is accepted.
- R10: Only address bits 11:0 select the array byte; bits 15:12 have no effect on the range check.
- R11: The status byte holds the lock bit in bit 7, the level in bits 3:2 and the write latch in bit 1; bits 6:4 and bit 0 read as 0.
- R12: Accept and reject are single-cycle pulses one clock after the request and never both high; when strobes coincide, status write takes precedence over memory write, then write-disarm, then write-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrProtN | input | 1 | Asynchronous active-low write-protect pin |
| cmdSetLatch | input | 1 | Write-arm strobe |
| cmdClrLatch | input | 1 | Write-disarm strobe |
| cmdStatWr | input | 1 | Status register write strobe |
| statWrData | input | 8 | Data byte for a status write |
| cmdMemWr | input | 1 | Memory write request strobe |
| memWrAddr | input | 16 | Byte address of the memory write |
| reqAccept | output | 1 | One-cycle pulse: last write request accepted |
| reqReject | output | 1 | One-cycle pulse: last write request rejected |
| statusByte | output | 8 | Current status byte |

## Verification
The bound checker watches, on every cycle, these rules:
- requests made without the latch are refused;
- a refusal leaves the status byte untouched;
- an acceptance clears the latch;
- status writes are refused under the hard lock;
- the full-array level refuses memory writes;
- the reserved status bits stay zero;
- accept and reject are exclusive.

Other behaviours are shown only by the bench's scenarios, which compare against a cycle-by-cycle model:
- reaching the hard lock in both orders and leaving it by releasing the pin;
- the two-edge synchronizer window;
- the exact boundaries of each protection level, including upper address bits being ignored;
- the precedence of coinciding strobes.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Status byte bit positions (read-back layout)
  localparam int STAT_W       = 8;
  localparam int LOCK_POS     = 7;
  localparam int LVL_HI_POS   = 3;
  localparam int LVL_LO_POS   = 2;
  localparam int LATCH_POS    = 1;
  localparam int LVL_W        = LVL_HI_POS - LVL_LO_POS + 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchSet;
    logic latchClr;
    logic statLoad;
    logic accept;
    logic reject;
  } wpStrobe_t;

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= pinIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], pinIn};
      end
    end
  endgenerate

  assign pinOut = chain[STAGES-1];

endmodule

// File: rtl/wp_range_chk.sv
module wp_range_chk #(
  parameter int ADDR_W = 12,
  parameter int LVL_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LVL_W-1:0]  level,
  output logic              inProt
);

  localparam int MAX_LVL = (1 << LVL_W) - 1;

  // Level n protects the region whose top (MAX_LVL - n) address bits are all ones.
  always_comb begin
    int need;
    logic hit;
    need = MAX_LVL - int'(level);
    hit  = 1'b1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= ADDR_W - need) hit = hit & addr[i];
    end
    inProt = (level != '0) && hit;
  end

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
(
  input  logic      cmdSetLatch,
  input  logic      cmdClrLatch,
  input  logic      cmdStatWr,
  input  logic      cmdMemWr,
  input  logic      latchQ,
  input  logic      lockQ,
  input  logic      pinHigh,
  input  logic      addrInProt,
  output wpStrobe_t stb
);

  logic hardLocked;
  assign hardLocked = lockQ & ~pinHigh;

  always_comb begin
    stb = '0;
    if (cmdStatWr) begin
      if (latchQ && !hardLocked) begin
        stb.accept   = 1'b1;
        stb.statLoad = 1'b1;
        stb.latchClr = 1'b1;
      end else begin
        stb.reject = 1'b1;
      end
    end else if (cmdMemWr) begin
      if (latchQ && !addrInProt) begin
        stb.accept   = 1'b1;
        stb.latchClr = 1'b1;
      end else begin
        stb.reject = 1'b1;
      end
    end else if (cmdClrLatch) begin
      stb.latchClr = 1'b1;
    end else if (cmdSetLatch) begin
      stb.latchSet = 1'b1;
    end
  end

endmodule

// File: rtl/wp_regs.sv
module wp_regs
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         stb,
  input  logic              lockIn,
  input  logic [LVL_W-1:0]  lvlIn,
  output logic              latchQ,
  output logic              lockQ,
  output logic [LVL_W-1:0]  lvlQ,
  output logic              acceptQ,
  output logic              rejectQ,
  output logic [STAT_W-1:0] statOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ  <= 1'b0;
      lockQ   <= 1'b0;
      lvlQ    <= '0;
      acceptQ <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      acceptQ <= stb.accept;
      rejectQ <= stb.reject;
      if (stb.latchClr)      latchQ <= 1'b0;
      else if (stb.latchSet) latchQ <= 1'b1;
      if (stb.statLoad) begin
        lockQ <= lockIn;
        lvlQ  <= lvlIn;
      end
    end
  end

  always_comb begin
    statOut = '0;
    statOut[LOCK_POS]              = lockQ;
    statOut[LVL_HI_POS:LVL_LO_POS] = lvlQ;
    statOut[LATCH_POS]             = latchQ;
  end

endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import wp_pkg::*;
#(
  parameter int MEM_ADDR_W   = 16,
  parameter int ARRAY_ADDR_W = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrProtN,
  input  logic                  cmdSetLatch,
  input  logic                  cmdClrLatch,
  input  logic                  cmdStatWr,
  input  logic [STAT_W-1:0]     statWrData,
  input  logic                  cmdMemWr,
  input  logic [MEM_ADDR_W-1:0] memWrAddr,
  output logic                  reqAccept,
  output logic                  reqReject,
  output logic [STAT_W-1:0]     statusByte
);

  localparam int IGN_W = MEM_ADDR_W - ARRAY_ADDR_W;

  logic             pinSynced;
  logic             latchQ;
  logic             lockQ;
  logic [LVL_W-1:0] lvlQ;
  logic             addrInProt;
  wpStrobe_t        stb;

  logic unusedBits;
  assign unusedBits = ^{statWrData[6:4], statWrData[1:0],
                        memWrAddr[MEM_ADDR_W-1 -: IGN_W]};

  wp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (wrProtN),
    .pinOut (pinSynced)
  );

  wp_range_chk #(.ADDR_W(ARRAY_ADDR_W), .LVL_W(LVL_W)) u_range (
    .addr   (memWrAddr[ARRAY_ADDR_W-1:0]),
    .level  (lvlQ),
    .inProt (addrInProt)
  );

  wp_ctrl u_ctrl (
    .cmdSetLatch (cmdSetLatch),
    .cmdClrLatch (cmdClrLatch),
    .cmdStatWr   (cmdStatWr),
    .cmdMemWr    (cmdMemWr),
    .latchQ      (latchQ),
    .lockQ       (lockQ),
    .pinHigh     (pinSynced),
    .addrInProt  (addrInProt),
    .stb         (stb)
  );

  wp_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .lockIn  (statWrData[LOCK_POS]),
    .lvlIn   (statWrData[LVL_HI_POS:LVL_LO_POS]),
    .latchQ  (latchQ),
    .lockQ   (lockQ),
    .lvlQ    (lvlQ),
    .acceptQ (reqAccept),
    .rejectQ (reqReject),
    .statOut (statusByte)
  );

endmodule

// File: rtl/eeprom_wp_chk.sv
module eeprom_wp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdSetLatch,
  input logic       cmdClrLatch,
  input logic       cmdStatWr,
  input logic       cmdMemWr,
  input logic       pinSynced,
  input logic       reqAccept,
  input logic       reqReject,
  input logic [7:0] statusByte
);

  // R3
  latch_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdStatWr || cmdMemWr) && !statusByte[1]) |=> reqReject);

  // R3
  reject_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> (statusByte == $past(statusByte)));

  // R4
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> !statusByte[1]);

  // R7
  hard_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStatWr && statusByte[7] && !pinSynced) |=> reqReject);

  // R9
  full_array_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdMemWr && !cmdStatWr && statusByte[3:2] == 2'b11) |=> reqReject);

  // R2
  arm_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSetLatch && !cmdClrLatch && !cmdStatWr && !cmdMemWr) |=> statusByte[1]);

  // R11
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6:4] == 3'b000) && !statusByte[0]);

  // R12
  exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqAccept && reqReject));

endmodule

bind eeprom_wp_ctrl eeprom_wp_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdSetLatch (cmdSetLatch),
  .cmdClrLatch (cmdClrLatch),
  .cmdStatWr   (cmdStatWr),
  .cmdMemWr    (cmdMemWr),
  .pinSynced   (pinSynced),
  .reqAccept   (reqAccept),
  .reqReject   (reqReject),
  .statusByte  (statusByte)
);

// File: tb/eeprom_wp_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_wp_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrProtN = 1'b1;
  logic        cmdSetLatch = 1'b0;
  logic        cmdClrLatch = 1'b0;
  logic        cmdStatWr = 1'b0;
  logic [7:0]  statWrData = 8'h00;
  logic        cmdMemWr = 1'b0;
  logic [15:0] memWrAddr = 16'h0000;
  logic        reqAccept;
  logic        reqReject;
  logic [7:0]  statusByte;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit started = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  eeprom_wp_ctrl u_eeprom_wp_ctrl (
    .clk(clk), .rstN(rstN), .wrProtN(wrProtN),
    .cmdSetLatch(cmdSetLatch), .cmdClrLatch(cmdClrLatch),
    .cmdStatWr(cmdStatWr), .statWrData(statWrData),
    .cmdMemWr(cmdMemWr), .memWrAddr(memWrAddr),
    .reqAccept(reqAccept), .reqReject(reqReject), .statusByte(statusByte)
  );

  // Behavioural reference model
  bit   mLatch = 0, mLock = 0, mAcc = 0, mRej = 0;
  int   mLvl = 0;
  bit   pipe[$];

  function automatic bit guarded(int lvl, int a);
    case (lvl)
      0:       return 0;
      1:       return a >= 'hC00;
      2:       return a >= 'h800;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit pinHi;
    started = 1;
    if (!rstN) begin
      mLatch = 0; mLock = 0; mLvl = 0; mAcc = 0; mRej = 0;
      pipe = '{1'b1, 1'b1};
    end else begin
      pinHi = pipe[0];
      void'(pipe.pop_front());
      pipe.push_back(wrProtN);
      mAcc = 0; mRej = 0;
      if (cmdStatWr) begin
        if (mLatch && !(mLock && !pinHi)) begin
          mAcc = 1; mLatch = 0;
          mLock = statWrData[7];
          mLvl = int'(statWrData[3:2]);
        end else mRej = 1;
      end else if (cmdMemWr) begin
        if (mLatch && !guarded(mLvl, int'(memWrAddr) % 4096)) begin
          mAcc = 1; mLatch = 0;
        end else mRej = 1;
      end else if (cmdClrLatch) mLatch = 0;
      else if (cmdSetLatch) mLatch = 1;
    end
  end

  function automatic logic [7:0] modelStat();
    return {mLock, 3'b000, 2'(mLvl), mLatch, 1'b0};
  endfunction

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (reqAccept !== mAcc || reqReject !== mRej || statusByte !== modelStat()) begin
        failures++;
        $display("FAIL %s model: acc=%0b rej=%0b stat=%02h expected acc=%0b rej=%0b stat=%02h",
                 phase, reqAccept, reqReject, statusByte, mAcc, mRej, modelStat());
      end
    end
  end

  task automatic checkOut(input bit expAcc, input bit expRej, input logic [7:0] expStat,
                          input string tag);
    checks++;
    if (reqAccept !== expAcc || reqReject !== expRej || statusByte !== expStat) begin
      failures++;
      $display("FAIL %s: acc=%0b rej=%0b stat=%02h expected acc=%0b rej=%0b stat=%02h",
               tag, reqAccept, reqReject, statusByte, expAcc, expRej, expStat);
    end
  endtask

  task automatic pulse(input bit s, input bit c, input bit sw, input bit mw,
                       input logic [7:0] d, input logic [15:0] a);
    @(negedge clk);
    cmdSetLatch = s; cmdClrLatch = c; cmdStatWr = sw; cmdMemWr = mw;
    statWrData = d; memWrAddr = a;
    @(negedge clk);
    cmdSetLatch = 0; cmdClrLatch = 0; cmdStatWr = 0; cmdMemWr = 0;
  endtask

  task automatic arm();       pulse(1, 0, 0, 0, 8'h00, 16'h0000); endtask
  task automatic statWr(input logic [7:0] d); pulse(0, 0, 1, 0, d, 16'h0000); endtask
  task automatic memWr(input logic [15:0] a);  pulse(0, 0, 0, 1, 8'h00, a); endtask

  task automatic setPin(input bit v);
    @(negedge clk);
    wrProtN = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    phase = "R1";
    checkOut(0, 0, 8'h00, "R1 reset state / R11 layout");

    phase = "R3";
    statWr(8'h8C);
    checkOut(0, 1, 8'h00, "R3 status write without latch");
    memWr(16'h0000);
    checkOut(0, 1, 8'h00, "R3 memory write without latch");

    phase = "R2";
    arm();
    checkOut(0, 0, 8'h02, "R2 arm latch");
    pulse(0, 1, 0, 0, 8'h00, 16'h0000);
    checkOut(0, 0, 8'h00, "R2 disarm latch");

    phase = "R5";
    arm();
    setPin(0);
    statWr(8'h8C);
    checkOut(1, 0, 8'h8C, "R5 lock bit 0 pin low accepted / R4 latch cleared");

    phase = "R7";
    arm();
    statWr(8'h00);
    checkOut(0, 1, 8'h8E, "R7 pin low then lock: status write rejected");
    memWr(16'h0123);
    checkOut(0, 1, 8'h8E, "R9 level 11 whole array");

    phase = "R6";
    setPin(1);
    statWr(8'h88);
    checkOut(1, 0, 8'h88, "R6 lock 1 pin high accepted");

    phase = "R9";
    arm();
    memWr(16'h07FF);
    checkOut(1, 0, 8'h88, "R9 level 10 below 0x800 accepted");
    arm();
    memWr(16'h0800);
    checkOut(0, 1, 8'h8A, "R9 level 10 at 0x800 rejected");
    phase = "R10";
    memWr(16'hF7FF);
    checkOut(1, 0, 8'h88, "R10 upper bits ignored accept");
    arm();
    memWr(16'h1800);
    checkOut(0, 1, 8'h8A, "R10 upper bits ignored reject");

    phase = "R8";
    @(negedge clk);
    wrProtN = 0; cmdStatWr = 1; statWrData = 8'h84;
    @(negedge clk);
    cmdStatWr = 0;
    checkOut(1, 0, 8'h84, "R8 pin fall not yet synchronized");
    repeat (3) @(negedge clk);

    phase = "R7";
    arm();
    statWr(8'h00);
    checkOut(0, 1, 8'h86, "R7 lock then pin low: rejected");

    phase = "R9";
    memWr(16'h0BFF);
    checkOut(1, 0, 8'h84, "R9 level 01 below 0xC00 accepted");
    arm();
    memWr(16'h0C00);
    checkOut(0, 1, 8'h86, "R9 level 01 at 0xC00 rejected");

    phase = "R7";
    setPin(1);
    statWr(8'h00);
    checkOut(1, 0, 8'h00, "R7 pin high releases lock");

    phase = "R5";
    setPin(0);
    arm();
    statWr(8'h0C);
    checkOut(1, 0, 8'h0C, "R5 lock 0 pin low accepted again");

    phase = "R12";
    pulse(1, 0, 1, 0, 8'h00, 16'h0000);
    checkOut(0, 1, 8'h0C, "R12 status write beats arm");
    pulse(1, 1, 0, 0, 8'h00, 16'h0000);
    checkOut(0, 0, 8'h0C, "R12 disarm beats arm");
    arm();
    pulse(0, 0, 0, 1, 8'h00, 16'h0000);
    checkOut(0, 1, 8'h0E, "R12 memory write rejected level 11");
    @(negedge clk);
    checkOut(0, 0, 8'h0E, "R12 reject is a single pulse");

    phase = "R3";
    memWr(16'h0000);
    checkOut(0, 1, 8'h0E, "R3 rejected memory write keeps latch");

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule